// File: doc/BRIEF.md
# Asynchronous Strobe-Handshake Register Bus Slave

This block is the processor-facing side of a peripheral that sits on an asynchronous, strobe-handshaked 8-bit bus. The processor drives a chip select, a data strobe, a read/write line, an interrupt-acknowledge line and an address. The block passes every control input through a two-flop synchronizer into the peripheral clock domain. It then decodes each bus cycle as a register read, a register write or an interrupt acknowledge. It answers each cycle with an active-low transfer-acknowledge a fixed number of clocks after the cycle is recognised.

The bidirectional data bus appears as separate input, output and output-enable ports. Pad logic outside the block joins them into one tri-state bus. On a read, the block drives the addressed register onto the bus. On an interrupt acknowledge, it drives an externally supplied vector. A write is committed only when the processor removes the data strobe after it has seen the acknowledge. A strobe that is removed before the acknowledge abandons the cycle and leaves the register array unchanged. One-cycle read and write strobes mark each register access for the logic around the block.

Top module: `pbus_slave`

## Requirements
- R1: With cs_n low, ds_n low and rw high, data_oe goes high and data_out equals the addressed register. Once cs_n or ds_n returns high, data_oe is low again by the third rising clock edge.
- R2: With cs_n low, ds_n low and rw low, the data_in value present when ds_n is raised after the acknowledge is stored in the register selected by addr. Reading that register afterwards returns this value.
- R3: For a read, a write and an interrupt acknowledge, dtack_n falls on the fifth rising clock edge after the starting strobe condition appears at the inputs. Two edges go to synchronization, one to detection and two to the acknowledge delay.
- R4: dtack_n returns high by the third rising clock edge after ds_n is raised.
- R5: After reset, dtack_n is high and data_oe is low. data_oe stays low except during a read or an interrupt-acknowledge cycle, so it is low during a write and while chip select is held without a strobe.
- R6: A write whose ds_n is raised before dtack_n has fallen writes no register and gives no reg_wr_stb pulse.
- R7: With iack_n low and ds_n low, data_oe goes high and data_out equals vector_in. Once iack_n or ds_n is high again, data_oe is low by the third rising clock edge. Interrupt acknowledge takes priority over chip select.
- R8: reg_rd_stb pulses for exactly one clock per read cycle. reg_wr_stb pulses for exactly one clock per committed write. The two never pulse together.
- R9: All registers read as 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | Direction: high for read, low for write |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| addr | input | ADDR_W | Register address, held stable for the whole cycle |
| data_in | input | DATA_W | Data bus as seen from the pads |
| vector_in | input | DATA_W | Vector driven during interrupt acknowledge |
| data_out | output | DATA_W | Value to drive onto the data bus |
| data_oe | output | 1 | Data bus output enable |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| reg_rd_stb | output | 1 | One-cycle pulse when a read cycle starts |
| reg_wr_stb | output | 1 | One-cycle pulse after a write is committed |

## Verification
The hardest case to reach from the ports is a write that is abandoned: the processor must raise the data strobe inside the short window after the synchronizers have seen it but before the acknowledge comes out. The bench reaches it by asserting the write strobe, waiting a single clock edge and then raising ds_n. It then confirms through the ports that dtack_n never fell and no write pulse appeared. A later read of the same address shows the old contents. A second hard case is a read ended by chip select alone while the strobe is held. The bench releases only cs_n and watches the output enable fall.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        CYC_RD   = 2'd0,
        CYC_WR   = 2'd1,
        CYC_IACK = 2'd2
    } cyc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } bus_state_t;

    // Synchronized control lines, all active high.
    typedef struct packed {
        logic cs;
        logic ds;
        logic rd;
        logic iack;
    } bus_ctl_t;

    typedef struct packed {
        logic      valid;
        cyc_kind_t kind;
    } cyc_req_t;

    localparam int CTL_W = $bits(bus_ctl_t);

    // Decode a cycle start; interrupt acknowledge wins over chip select.
    function automatic cyc_req_t decode_start(bus_ctl_t c);
        cyc_req_t r;
        r.valid = 1'b0;
        r.kind  = CYC_RD;
        if (c.iack && c.ds) begin
            r.valid = 1'b1;
            r.kind  = CYC_IACK;
        end else if (c.cs && c.ds) begin
            r.valid = 1'b1;
            r.kind  = c.rd ? CYC_RD : CYC_WR;
        end
        return r;
    endfunction

    // Whether the qualifying condition of a running cycle still holds.
    function automatic logic cycle_held(bus_ctl_t c, cyc_kind_t k);
        logic h;
        case (k)
            CYC_RD:   h = c.cs && c.ds && c.rd;
            CYC_WR:   h = c.cs && c.ds && !c.rd;
            CYC_IACK: h = c.iack && c.ds;
            default:  h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= '0;
                else if (we && (waddr == ADDR_W'(i)))
                    mem[i] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem[raddr];
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
    import pbus_pkg::*;
#(
    parameter int ACK_DLY = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_ctl_t  ctl,
    output logic      start,
    output cyc_kind_t start_kind,
    output logic      commit,
    output logic      ack,
    output logic      oe,
    output logic      rd_stb,
    output logic      wr_stb
);
    localparam int CNT_W = (ACK_DLY > 1) ? $clog2(ACK_DLY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DLY - 1);

    bus_state_t     state;
    cyc_kind_t      kind;
    logic [CNT_W-1:0] cnt;
    cyc_req_t       req;
    logic           held;

    always_comb begin
        req        = decode_start(ctl);
        held       = cycle_held(ctl, kind);
        start      = (state == ST_IDLE) && req.valid;
        start_kind = req.kind;
        commit     = (state == ST_ACK) && (kind == CYC_WR) && !ctl.ds;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind   <= CYC_RD;
            cnt    <= '0;
            ack    <= 1'b0;
            oe     <= 1'b0;
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
        end else begin
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        kind   <= req.kind;
                        cnt    <= '0;
                        oe     <= (req.kind != CYC_WR);
                        rd_stb <= (req.kind == CYC_RD);
                        state  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!held) begin
                        oe    <= 1'b0;
                        state <= ST_IDLE;
                    end else if (cnt == CNT_LAST) begin
                        ack   <= 1'b1;
                        state <= ST_ACK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ACK: begin
                    if (kind == CYC_WR) begin
                        if (!ctl.ds) begin
                            wr_stb <= 1'b1;
                            ack    <= 1'b0;
                            state  <= ST_IDLE;
                        end else if (!ctl.cs) begin
                            ack   <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end else if (!held) begin
                        ack   <= 1'b0;
                        oe    <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
    import pbus_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int SYNC_N  = 2,
    parameter int ACK_DLY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic              iack_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] vector_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              dtack_n,
    output logic              reg_rd_stb,
    output logic              reg_wr_stb
);
    bus_ctl_t          ctl_raw;
    bus_ctl_t          ctl;
    logic [DATA_W-1:0] data_s;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rf_rdata;
    logic              start;
    cyc_kind_t         start_kind;
    logic              commit;
    logic              ack;

    assign ctl_raw = '{cs: !cs_n, ds: !ds_n, rd: rw, iack: !iack_n};

    pbus_sync #(.WIDTH(CTL_W), .STAGES(SYNC_N)) u_ctl_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl)
    );

    // Data follows the same latency so it lines up with the strobe edge.
    pbus_sync #(.WIDTH(DATA_W), .STAGES(SYNC_N)) u_dat_sync (
        .clk (clk),
        .rst (rst),
        .d   (data_in),
        .q   (data_s)
    );

    pbus_ctrl #(.ACK_DLY(ACK_DLY)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .start      (start),
        .start_kind (start_kind),
        .commit     (commit),
        .ack        (ack),
        .oe         (data_oe),
        .rd_stb     (reg_rd_stb),
        .wr_stb     (reg_wr_stb)
    );

    pbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .waddr (addr_q),
        .wdata (data_s),
        .raddr (addr),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            data_out <= '0;
        end else if (start) begin
            addr_q   <= addr;
            data_out <= (start_kind == CYC_IACK) ? vector_in : rf_rdata;
        end
    end

    assign dtack_n = !ack;
endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk (
    input logic clk,
    input logic rst,
    input logic dtack_n,
    input logic data_oe,
    input logic reg_rd_stb,
    input logic reg_wr_stb,
    input logic ds_act,
    input logic cs_act,
    input logic iack_act
);
    a_r8_rd_one_cycle: assert property (@(posedge clk) disable iff (rst)
        reg_rd_stb |=> !reg_rd_stb);

    a_r8_wr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        reg_wr_stb |=> !reg_wr_stb);

    a_r8_not_both: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_stb && reg_wr_stb));

    a_r6_write_after_ack: assert property (@(posedge clk) disable iff (rst)
        reg_wr_stb |-> $past(!dtack_n));

    a_r3_strobe_held: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> ($past(ds_act, 1) && $past(ds_act, 2)));

    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && !ds_act) |=> dtack_n);

    a_r5_oe_source: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe) |-> $past(cs_act || iack_act));
endmodule

bind pbus_slave pbus_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dtack_n    (dtack_n),
    .data_oe    (data_oe),
    .reg_rd_stb (reg_rd_stb),
    .reg_wr_stb (reg_wr_stb),
    .ds_act     (ctl.ds),
    .cs_act     (ctl.cs),
    .iack_act   (ctl.iack)
);

// File: tb/sim_pbus_slave.sv
module sim_pbus_slave;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1, iack_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0, vector_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe, dtack_n, reg_rd_stb, reg_wr_stb;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_pulses = 0;
    int rd_pulses = 0;
    int ack_falls = 0;
    bit done = 1'b0;

    typedef struct { logic [DW-1:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_slave u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ds_n(ds_n), .rw(rw),
        .iack_n(iack_n), .addr(addr), .data_in(data_in),
        .vector_in(vector_in), .data_out(data_out), .data_oe(data_oe),
        .dtack_n(dtack_n), .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every acknowledged read or vector cycle.
    logic prev_dtack = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr_stb) wr_pulses++;
            if (reg_rd_stb) rd_pulses++;
            if (prev_dtack && !dtack_n) begin
                ack_falls++;
                if (data_oe) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1 unexpected data", data_out, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(data_out === e.val, e.tag, data_out, e.val);
                    end
                end
            end
        end
        prev_dtack = dtack_n;
    end

    // Counts rising edges until dtack_n reaches the wanted level.
    task automatic wait_dtack(input logic lvl, output int edges);
        edges = 0;
        do begin
            @(posedge clk); edges++;
            @(negedge clk);
        end while (dtack_n !== lvl && edges < 20);
    endtask

    task automatic wait_oe_low(output int edges);
        edges = 0;
        while (data_oe !== 1'b0 && edges < 20) begin
            @(posedge clk); edges++;
            @(negedge clk);
        end
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        int n;
        int rp;
        rp = rd_pulses;
        exp_q.push_back('{val: e, tag: tag});
        @(negedge clk);
        addr = a; rw = 1'b1; cs_n = 1'b0; ds_n = 1'b0;
        wait_dtack(1'b0, n);
        chk(n == 5, "R3 read ack latency", n, 5);
        ds_n = 1'b1; cs_n = 1'b1;
        wait_dtack(1'b1, n);
        chk(n <= 3, "R4 read ack release", n, 3);
        wait_oe_low(n);
        chk(data_oe === 1'b0, "R1 oe after read", data_oe, 0);
        repeat (2) @(negedge clk);
        chk(rd_pulses == rp + 1, "R8 one read pulse", rd_pulses - rp, 1);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n;
        int wp;
        wp = wr_pulses;
        @(negedge clk);
        addr = a; data_in = d; rw = 1'b0; cs_n = 1'b0; ds_n = 1'b0;
        wait_dtack(1'b0, n);
        chk(n == 5, "R3 write ack latency", n, 5);
        chk(data_oe === 1'b0, "R5 oe low in write", data_oe, 0);
        ds_n = 1'b1;
        wait_dtack(1'b1, n);
        chk(n <= 3, "R4 write ack release", n, 3);
        repeat (2) @(negedge clk);
        cs_n = 1'b1; rw = 1'b1;
        repeat (2) @(negedge clk);
        chk(wr_pulses == wp + 1, "R8 one write pulse", wr_pulses - wp, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int wp;
        int af;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dtack_n === 1'b1, "R5 reset dtack", dtack_n, 1);
        chk(data_oe === 1'b0, "R5 reset oe", data_oe, 0);

        bus_read(4'd3, 8'h00, "R9 reset value reg3");
        bus_read(4'd15, 8'h00, "R9 reset value reg15");

        bus_write(4'd3, 8'hA5);
        bus_write(4'd12, 8'h5A);
        bus_write(4'd15, 8'hFF);
        bus_write(4'd0, 8'h01);
        bus_read(4'd3, 8'hA5, "R2 readback reg3");
        bus_read(4'd12, 8'h5A, "R2 readback reg12");
        bus_read(4'd15, 8'hFF, "R2 readback reg15");
        bus_read(4'd0, 8'h01, "R2 readback reg0");
        bus_write(4'd3, 8'h3C);
        bus_read(4'd3, 8'h3C, "R2 overwrite reg3");

        // R6: strobe removed before the acknowledge.
        wp = wr_pulses; af = ack_falls;
        @(negedge clk);
        addr = 4'd3; data_in = 8'h99; rw = 1'b0; cs_n = 1'b0; ds_n = 1'b0;
        @(posedge clk); @(negedge clk);
        ds_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(ack_falls == af, "R6 no ack on early release", ack_falls - af, 0);
        chk(wr_pulses == wp, "R6 no write pulse", wr_pulses - wp, 0);
        cs_n = 1'b1; rw = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(4'd3, 8'h3C, "R6 register unchanged");

        // R5: chip select without strobe.
        @(negedge clk);
        cs_n = 1'b0; rw = 1'b1;
        repeat (6) begin
            @(negedge clk);
            chk(data_oe === 1'b0 && dtack_n === 1'b1, "R5 idle select", data_oe, 0);
        end
        cs_n = 1'b1;

        // R1: read ended by chip select alone.
        exp_q.push_back('{val: 8'h5A, tag: "R1 read reg12"});
        @(negedge clk);
        addr = 4'd12; rw = 1'b1; cs_n = 1'b0; ds_n = 1'b0;
        wait_dtack(1'b0, n);
        chk(data_oe === 1'b1, "R1 oe during read", data_oe, 1);
        cs_n = 1'b1;
        wait_oe_low(n);
        chk(n <= 3, "R1 read ends on select release", n, 3);
        ds_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7: interrupt acknowledge, with chip select also low to show priority.
        vector_in = 8'h4E;
        exp_q.push_back('{val: 8'h4E, tag: "R7 vector"});
        @(negedge clk);
        addr = 4'd0; rw = 1'b1; cs_n = 1'b0; iack_n = 1'b0; ds_n = 1'b0;
        wait_dtack(1'b0, n);
        chk(n == 5, "R3 iack ack latency", n, 5);
        iack_n = 1'b1; cs_n = 1'b1;
        wait_oe_low(n);
        chk(n <= 3, "R7 oe drops on iack release", n, 3);
        ds_n = 1'b1;
        repeat (3) @(negedge clk);

        vector_in = 8'hC1;
        exp_q.push_back('{val: 8'hC1, tag: "R7 vector second"});
        @(negedge clk);
        iack_n = 1'b0; ds_n = 1'b0;
        wait_dtack(1'b0, n);
        ds_n = 1'b1;
        wait_oe_low(n);
        chk(n <= 3, "R7 oe drops on strobe release", n, 3);
        iack_n = 1'b1;
        repeat (4) @(negedge clk);

        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule